// File: doc/BRIEF.md
# Parallel Receive Sample-Enable Controller

This block sits at the front of a parallel receive path and decides, one clock at a time, whether the word on the data bus is taken. It picks one of sixteen candidate enable lines and can invert it. It then applies one of three gating schemes to that conditioned enable. The first, level gating, takes a word on every cycle the enable is active. The second, pulse framing, uses rising edges of the enable to open and close frames. The third, software gating, takes words while a control bit is set.

Pulse framing has six variants. Four of them close the frame on the next rising edge, and each of these decides on its own whether the word on the opening edge is kept and whether the word on the closing edge is kept. The other two close the frame after a programmed number of words, and differ only in whether the opening word is kept. Each taken word appears on the output one clock later with a valid strobe. An end-of-frame flag marks where a frame closes. All configuration arrives on plain input ports.

Top module: `prx_sample_gate`

## Requirements
- R1: While `rst_n` is low on a clock edge, `out_valid`, `out_eof` and `out_data` become 0, no frame is open and the word counter is cleared.
- R2: The conditioned enable in any cycle is `en_lines[en_sel]` XOR `en_inv`.
- R3: With `mode_sel` = 0 (level gating), the word on `data_in` is taken in every cycle where the conditioned enable is 1. A word taken in cycle t shows on `out_data` with `out_valid` = 1 after the clock edge that ends cycle t. `out_eof` stays 0.
- R4: With `mode_sel` = 2 (software gating), a word is taken in every cycle where `sw_en` is 1, whatever the enable lines carry. `out_eof` stays 0.
- R5: With `mode_sel` = 1, a rising edge is a cycle where the conditioned enable is 1 and was 0 in the previous cycle. For `sub_sel` 0 to 3, a rising edge with no open frame opens one, every cycle inside the frame takes its word, and the next rising edge closes the frame. The opening-edge word is kept for `sub_sel` 0 and 1 and dropped for 2 and 3. The closing-edge word is kept for 0 and 2 and dropped for 1 and 3.
- R6: In `sub_sel` 0 to 3, `out_eof` is 1 in the output cycle of the closing edge. It comes with `out_valid` = 1 when the closing word is kept, and alone with `out_valid` = 0 when it is dropped.
- R7: For `sub_sel` 4 and 5, a rising edge opens a frame. `sub_sel` 4 keeps the opening word and counts it; `sub_sel` 5 drops it and does not count it. The frame closes once `frame_len` words have been taken, and `out_eof` is set together with `out_valid` on the last word. A `frame_len` of 0 acts as 1. Rising edges inside an open frame are ignored.
- R8: `mode_sel` = 3, and `mode_sel` = 1 with `sub_sel` 6 or 7, never assert `out_valid` or `out_eof`.
- R9: A cycle whose `mode_sel` or `sub_sel` differs from the previous cycle takes no word and asserts no `out_eof`, and it closes any open frame.
- R10: An enable held high opens or closes a frame only once, on its rising edge. In edge-closed submodes it does not reopen a frame until it has fallen and risen again.
- R11: `out_data` changes only on a cycle with `out_valid` = 1 and otherwise holds the last word taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_lines | input | NUM_EN (16) | Candidate external enable lines |
| en_sel | input | SEL_W (4) | Index of the enable line in use |
| en_inv | input | 1 | Inverts the selected enable |
| sw_en | input | 1 | Software capture enable |
| mode_sel | input | 2 | 0 level, 1 pulse, 2 software, 3 undefined |
| sub_sel | input | 3 | Pulse submode 0 to 5; 6 and 7 undefined |
| frame_len | input | LEN_W (8) | Word count for length-closed frames |
| data_in | input | DATA_W (8) | Parallel receive data |
| out_data | output | DATA_W (8) | Last taken word |
| out_valid | output | 1 | A word was taken in the previous cycle |
| out_eof | output | 1 | A frame closed in the previous cycle |

## Verification
The assertions assume that every input carries a known value from time zero and keeps it through reset. They also assume that `frame_len` does not change while a length-closed frame is open, because the counter bound is checked against the current length. The stimulus drives all ports before the first edge and holds reset for several cycles. It changes `frame_len` only one cycle after a submode change, when that change has already closed any frame. Enable patterns, data words and software enable come from a bench-local shift register, while the bench steps mode, submode, inversion and line index through every defined and undefined value.

// File: rtl/prx_gate_pkg.sv
package prx_gate_pkg;

  typedef enum logic [1:0] {
    SMP_LEVEL = 2'd0,
    SMP_PULSE = 2'd1,
    SMP_SOFT  = 2'd2,
    SMP_RSVD  = 2'd3
  } smp_mode_e;

  // Submode helpers: each answers one question about a 3-bit pulse submode.
  function automatic logic sub_defined(input logic [2:0] s);
    return s <= 3'd5;
  endfunction

  function automatic logic sub_len_closed(input logic [2:0] s);
    return (s == 3'd4) || (s == 3'd5);
  endfunction

  function automatic logic sub_keep_open(input logic [2:0] s);
    return (s == 3'd0) || (s == 3'd1) || (s == 3'd4);
  endfunction

  function automatic logic sub_keep_close(input logic [2:0] s);
    return (s == 3'd0) || (s == 3'd2);
  endfunction

  // A programmed length of zero behaves as one word.
  function automatic logic [31:0] eff_len(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

  // True when taking one more word reaches the programmed length.
  function automatic logic reaches_len(input logic [31:0] taken, input logic [31:0] len);
    return (taken + 32'd1) >= eff_len(len);
  endfunction

endpackage

// File: rtl/prx_en_cond.sv
module prx_en_cond #(
  parameter int NUM_EN = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic [NUM_EN-1:0] en_lines,
  input  logic [SEL_W-1:0]  en_sel,
  input  logic              en_inv,
  output logic              cond_en,
  output logic              rise
);

  logic [NUM_EN-1:0] hit;
  logic              prev_q;

  // One-hot AND-OR select across the candidate lines.
  for (genvar g = 0; g < NUM_EN; g++) begin : g_sel
    assign hit[g] = en_lines[g] & (en_sel == SEL_W'(g));
  end

  assign cond_en = (|hit) ^ en_inv;

  // The previous level tracks even in reset so that no false edge appears at release.
  always_ff @(posedge clk) begin
    prev_q <= cond_en;
  end

  assign rise = cond_en & ~prev_q;

endmodule

// File: rtl/prx_frame_fsm.sv
module prx_frame_fsm
  import prx_gate_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_en,
  input  logic             rise,
  input  logic             sw_en,
  input  logic [1:0]       mode_sel,
  input  logic [2:0]       sub_sel,
  input  logic [LEN_W-1:0] frame_len,
  output logic             take,
  output logic             last,
  output logic             cfg_chg
);

  logic             open_q, open_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]       mode_q;
  logic [2:0]       sub_q;
  logic             len_hit;

  assign cfg_chg = (mode_sel != mode_q) || (sub_sel != sub_q);
  assign len_hit = reaches_len(32'(cnt_q), 32'(frame_len));

  always_comb begin
    take   = 1'b0;
    last   = 1'b0;
    open_d = open_q;
    cnt_d  = cnt_q;
    if (cfg_chg) begin
      open_d = 1'b0;
      cnt_d  = '0;
    end else begin
      case (mode_sel)
        SMP_LEVEL: begin
          take   = cond_en;
          open_d = 1'b0;
          cnt_d  = '0;
        end
        SMP_SOFT: begin
          take   = sw_en;
          open_d = 1'b0;
          cnt_d  = '0;
        end
        SMP_PULSE: begin
          if (!sub_defined(sub_sel)) begin
            open_d = 1'b0;
            cnt_d  = '0;
          end else if (sub_len_closed(sub_sel)) begin
            if (!open_q) begin
              if (rise) begin
                take = sub_keep_open(sub_sel);
                if (sub_keep_open(sub_sel) && reaches_len(32'd0, 32'(frame_len))) begin
                  last   = 1'b1;
                  open_d = 1'b0;
                  cnt_d  = '0;
                end else begin
                  open_d = 1'b1;
                  cnt_d  = sub_keep_open(sub_sel) ? LEN_W'(1) : '0;
                end
              end
            end else begin
              take = 1'b1;
              if (len_hit) begin
                last   = 1'b1;
                open_d = 1'b0;
                cnt_d  = '0;
              end else begin
                cnt_d = cnt_q + LEN_W'(1);
              end
            end
          end else begin
            if (!open_q) begin
              if (rise) begin
                open_d = 1'b1;
                take   = sub_keep_open(sub_sel);
              end
            end else if (rise) begin
              open_d = 1'b0;
              last   = 1'b1;
              take   = sub_keep_close(sub_sel);
            end else begin
              take = 1'b1;
            end
          end
        end
        default: begin
          open_d = 1'b0;
          cnt_d  = '0;
        end
      endcase
    end
  end

  // Configuration history tracks during reset; frame state clears.
  always_ff @(posedge clk) begin
    mode_q <= mode_sel;
    sub_q  <= sub_sel;
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      cnt_q  <= cnt_d;
    end
  end

  // R7: an open length-closed frame never holds a count at or past its length.
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && mode_q == SMP_PULSE && sub_len_closed(sub_q))
      |-> (32'(cnt_q) < eff_len(32'(frame_len))));

  // R9: a frame is only ever open after a cycle in a defined pulse submode.
  a_r9_open_pulse_only: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> ($past(mode_sel) == SMP_PULSE && $past(sub_sel) <= 3'd5));

endmodule

// File: rtl/prx_out_stage.sv
module prx_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              last,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_eof
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      out_valid <= take;
      out_eof   <= last;
      if (take) out_data <= data_in;
    end
  end

  // R11: the data word moves only alongside a valid strobe.
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(rst_n)) |-> $stable(out_data));

endmodule

// File: rtl/prx_sample_gate.sv
module prx_sample_gate
  import prx_gate_pkg::*;
#(
  parameter int NUM_EN = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  localparam int SEL_W = (NUM_EN > 1) ? $clog2(NUM_EN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EN-1:0] en_lines,
  input  logic [SEL_W-1:0]  en_sel,
  input  logic              en_inv,
  input  logic              sw_en,
  input  logic [1:0]        mode_sel,
  input  logic [2:0]        sub_sel,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_eof
);

  logic cond_en;
  logic rise;
  logic take;
  logic last;
  logic cfg_chg;

  prx_en_cond #(.NUM_EN(NUM_EN), .SEL_W(SEL_W)) u_cond (
    .clk      (clk),
    .en_lines (en_lines),
    .en_sel   (en_sel),
    .en_inv   (en_inv),
    .cond_en  (cond_en),
    .rise     (rise)
  );

  prx_frame_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_en   (cond_en),
    .rise      (rise),
    .sw_en     (sw_en),
    .mode_sel  (mode_sel),
    .sub_sel   (sub_sel),
    .frame_len (frame_len),
    .take      (take),
    .last      (last),
    .cfg_chg   (cfg_chg)
  );

  prx_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .last      (last),
    .data_in   (data_in),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_eof   (out_eof)
  );

  // R3: steady level gating follows the conditioned enable one cycle later.
  a_r3_level: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_sel) == SMP_LEVEL && $past(mode_sel, 2) == SMP_LEVEL
       && $past(sub_sel) == $past(sub_sel, 2))
      |-> (out_valid == $past(cond_en) && !out_eof));

  // R4: steady software gating follows sw_en one cycle later.
  a_r4_soft: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_sel) == SMP_SOFT && $past(mode_sel, 2) == SMP_SOFT
       && $past(sub_sel) == $past(sub_sel, 2))
      |-> (out_valid == $past(sw_en) && !out_eof));

  // R8: undefined encodings raise neither strobe.
  a_r8_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_eof)
      |-> ($past(mode_sel) != SMP_RSVD
           && !($past(mode_sel) == SMP_PULSE && $past(sub_sel) > 3'd5)));

  // R9: a configuration change cycle produces no strobe at all.
  a_r9_no_eof_on_chg: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_chg) && $past(rst_n)) |-> (!out_valid && !out_eof));

endmodule

// File: tb/prx_sample_gate_bench.sv
module prx_sample_gate_bench;

  localparam int NUM_EN = 16;
  localparam int DATA_W = 8;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NUM_EN-1:0] en_lines;
  logic [3:0]        en_sel;
  logic              en_inv;
  logic              sw_en;
  logic [1:0]        mode_sel;
  logic [2:0]        sub_sel;
  logic [LEN_W-1:0]  frame_len;
  logic [DATA_W-1:0] data_in;
  logic [DATA_W-1:0] out_data;
  logic              out_valid;
  logic              out_eof;

  int    n_vec  = 0;
  int    n_bad  = 0;
  string tag    = "R1";
  logic [15:0] lfsr = 16'hACE1;

  // Reference state kept by the bench.
  logic        m_prev = 1'b0;
  logic [1:0]  m_mode = 2'd0;
  logic [2:0]  m_sub  = 3'd0;
  logic        m_open = 1'b0;
  int          m_cnt  = 0;
  logic [DATA_W-1:0] e_data = '0;
  logic        e_valid = 1'b0;
  logic        e_eof   = 1'b0;

  always #5 clk = ~clk;

  prx_sample_gate #(.NUM_EN(NUM_EN), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_prx_sample_gate (
    .clk (clk), .rst_n (rst_n), .en_lines (en_lines), .en_sel (en_sel),
    .en_inv (en_inv), .sw_en (sw_en), .mode_sel (mode_sel), .sub_sel (sub_sel),
    .frame_len (frame_len), .data_in (data_in),
    .out_data (out_data), .out_valid (out_valid), .out_eof (out_eof)
  );

  function automatic logic [15:0] adv(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Predict this cycle's outcome from the requirements, clock, then compare.
  task automatic step();
    logic c, edge_seen, keep_o, keep_c, changed;
    int   len;
    c         = en_lines[en_sel] ^ en_inv;
    edge_seen = c && !m_prev;
    changed   = (mode_sel != m_mode) || (sub_sel != m_sub);
    keep_o    = (sub_sel == 3'd0) || (sub_sel == 3'd1) || (sub_sel == 3'd4);
    keep_c    = (sub_sel == 3'd0) || (sub_sel == 3'd2);
    len       = (frame_len == 0) ? 1 : int'(frame_len);
    e_valid   = 1'b0;
    e_eof     = 1'b0;
    if (!rst_n) begin
      m_open = 1'b0; m_cnt = 0; e_data = '0;
    end else if (changed) begin
      m_open = 1'b0; m_cnt = 0;
    end else if (mode_sel == 2'd0) begin
      e_valid = c;
    end else if (mode_sel == 2'd2) begin
      e_valid = sw_en;
    end else if (mode_sel == 2'd1 && sub_sel <= 3'd3) begin
      if (m_open && edge_seen) begin
        m_open = 1'b0; e_eof = 1'b1; e_valid = keep_c;
      end else if (m_open) begin
        e_valid = 1'b1;
      end else if (edge_seen) begin
        m_open = 1'b1; e_valid = keep_o;
      end
    end else if (mode_sel == 2'd1 && sub_sel <= 3'd5) begin
      if (m_open) begin
        e_valid = 1'b1;
        m_cnt   = m_cnt + 1;
        if (m_cnt >= len) begin m_open = 1'b0; m_cnt = 0; e_eof = 1'b1; end
      end else if (edge_seen) begin
        e_valid = keep_o;
        m_cnt   = keep_o ? 1 : 0;
        if (keep_o && len == 1) begin m_cnt = 0; e_eof = 1'b1; end
        else m_open = 1'b1;
      end
    end
    if (e_valid) e_data = data_in;
    m_prev = c; m_mode = mode_sel; m_sub = sub_sel;
    @(posedge clk);
    #1;
    n_vec++;
    if (out_valid !== e_valid || out_eof !== e_eof || out_data !== e_data) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b eof=%0b data=%h, expected valid=%0b eof=%0b data=%h",
               tag, out_valid, out_eof, out_data, e_valid, e_eof, e_data);
    end
    lfsr    = adv(lfsr);
    data_in = lfsr[DATA_W-1:0];
  endtask

  task automatic set_en(input logic v);
    lfsr = adv(lfsr);
    en_lines = lfsr;
    en_lines[en_sel] = v ^ en_inv;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_lines = '0; en_sel = 4'd7; en_inv = 1'b0; sw_en = 1'b0;
    mode_sel = 2'd0; sub_sel = 3'd0; frame_len = 8'd3; data_in = 8'h5A;

    // R1: reset state, with the enable active so reset must dominate.
    tag = "R1";
    en_lines = '1;
    repeat (5) step();
    rst_n = 1'b1;
    en_lines = '0;

    // R2: every line index and inversion, walking a single active line.
    tag = "R2 R3";
    for (int s = 0; s < NUM_EN; s++) begin
      for (int iv = 0; iv < 2; iv++) begin
        en_sel = 4'(s); en_inv = iv[0];
        for (int k = 0; k < NUM_EN; k++) begin
          en_lines = NUM_EN'(1) << k;
          step();
        end
      end
    end

    // R3 and R11: random level gating on line 7.
    tag = "R3 R11";
    en_sel = 4'd7; en_inv = 1'b0;
    for (int i = 0; i < 200; i++) begin
      set_en(lfsr[2]);
      step();
    end

    // R4: software gating, enable lines as noise.
    tag = "R4";
    mode_sel = 2'd2;
    for (int i = 0; i < 200; i++) begin
      lfsr = adv(lfsr);
      en_lines = lfsr;
      sw_en = lfsr[5];
      step();
    end
    sw_en = 1'b0;

    // R5 R6 R7 R10: every defined pulse submode, both polarities, several lengths.
    mode_sel = 2'd1;
    for (int sm = 0; sm < 6; sm++) begin
      for (int iv = 0; iv < 2; iv++) begin
        for (int fl = 0; fl < 4; fl++) begin
          tag = (sm < 4) ? "R5 R6 R10" : "R7 R10";
          en_inv = iv[0];
          set_en(1'b0);
          sub_sel = 3'(sm);
          step();
          frame_len = 8'(fl);
          for (int i = 0; i < 60; i++) begin
            set_en(lfsr[3:1] < 3'd3 || (lfsr[9] && lfsr[10]));
            step();
          end
          sub_sel = 3'(5 - sm);
          step();
        end
      end
    end

    // R8: undefined mode and submodes with heavy enable activity.
    tag = "R8 R11";
    mode_sel = 2'd3; sub_sel = 3'd0;
    for (int i = 0; i < 100; i++) begin
      set_en(lfsr[1]); sw_en = lfsr[4];
      step();
    end
    mode_sel = 2'd1;
    for (int u = 6; u < 8; u++) begin
      sub_sel = 3'(u);
      for (int i = 0; i < 100; i++) begin
        set_en(lfsr[1]);
        step();
      end
    end
    sw_en = 1'b0;

    // R9: open a frame, then switch submode or mode mid-frame.
    tag = "R9";
    en_inv = 1'b0; frame_len = 8'd6;
    for (int a = 0; a < 6; a++) begin
      mode_sel = 2'd1; sub_sel = 3'(a);
      set_en(1'b0); step(); step();
      set_en(1'b1); step();
      set_en(1'b0); step(); step();
      sub_sel = 3'((a + 1) % 6);
      step(); step();
      set_en(1'b1); step();
      set_en(1'b1); mode_sel = 2'd0; step(); step();
      set_en(1'b0); step();
    end

    summary();
    $finish;
  end

endmodule